// File: doc/BRIEF.md
# Nine-bit UART transmitter with line inversion

This block is the transmit half of an asynchronous serial port. Software writes a control byte that holds a sticky ninth-bit value, a line-polarity switch and a pin-direction switch. Each write of a data byte takes that byte, together with the ninth bit held at that moment, into a one-word holding buffer. When the bit engine is idle, it moves the buffer into the shift register. It then sends a start bit, the data lsb first, the ninth bit when nine-bit mode is on, and a stop bit. Each bit lasts a fixed number of baud ticks, which come from an external rate generator.

A break request holds the line at its active-low level for whole frame lengths. All line states, including idle and break, can be inverted at the pin. In single-wire half-duplex mode the direction bit decides whether the pin is driven. The internal, uninverted line value is also offered to a receiver as a loop-back source.

Top module: `uart9_tx`

## Requirements
- R1: After reset the pin shows the idle level 1, the empty flag is 1, the pin output-enable is 1 and all control bits are 0.
- R2: A character with nine-bit mode off is 10 bits: a 0 start bit, 8 data bits lsb first, and a 1 stop bit. Each bit lasts 16 baud ticks, counted from the cycle after the buffer is moved into the shifter.
- R3: With nine-bit mode on, the character is 11 bits, and the bit after the data msb is the captured ninth bit.
- R4: The ninth bit is control bit 6, and it is captured when the data byte is written. A control write in the same cycle as that data write, or any later one, does not change that character.
- R5: The ninth bit keeps its value across data writes until the control byte is written again.
- R6: While the break request is held and the engine is idle, the line goes to 0 for one frame length (10 or 11 bit times). It repeats for as long as the request is held. A break takes precedence over a waiting buffer.
- R7: The empty flag is set in the cycle the buffer moves into the shifter and is cleared by a data write. If both happen in the same cycle, the write wins. A write while the buffer is full replaces its contents.
- R8: Control bit 4 inverts the pin for every line state: idle, start, data, ninth, stop and break.
- R9: With both single-wire inputs high and control bit 5 at 0, the pin output-enable is 0. In every other case it is 1.
- R10: The loop-back output always equals the uninverted line value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| baud_tick_i | input | 1 | One-cycle pulse per baud tick |
| nine_bit_i | input | 1 | Nine-bit character mode |
| sw_loop_i | input | 1 | Single-wire selection, first half |
| sw_src_i | input | 1 | Single-wire selection, second half |
| ctl_wr_i | input | 1 | Control byte write strobe |
| ctl_i | input | 8 | Control byte (bit 6 ninth bit, bit 5 direction, bit 4 invert) |
| dat_wr_i | input | 1 | Data byte write strobe |
| dat_i | input | 8 | Data byte |
| brk_req_i | input | 1 | Break request |
| tx_o | output | 1 | Serial pin value |
| tx_oe_o | output | 1 | Pin output-enable |
| rx_loop_o | output | 1 | Uninverted line for the receiver |
| tde_o | output | 1 | Transmit buffer empty flag |

## Verification
Two events can land in the same clock edge: a data write, and the move of the buffer into the shifter. The bench provokes this by issuing two data writes on consecutive cycles while the engine is idle, so the second write meets the load. The empty flag must then stay 0, and the second byte must follow the first frame. A control write in the same cycle as a data write is also provoked. For that case the ninth bit sampled in mid-bit must be the old value, and the next character must carry the new one.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_DATA = 2'd1,
    SH_BRK  = 2'd2
  } sh_state_e;
endpackage

// File: rtl/uart9_ctl.sv
module uart9_ctl #(
  parameter int CTL_W   = 8,
  parameter int NINE_POS = 6,
  parameter int DIR_POS  = 5,
  parameter int INV_POS  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic             nine_o,
  output logic             dir_o,
  output logic             inv_o
);
  logic nine_q, dir_q, inv_q;
  logic nine_d, dir_d, inv_d;

  always_comb begin
    nine_d = nine_q;
    dir_d  = dir_q;
    inv_d  = inv_q;
    if (wr_i) begin
      nine_d = wdata_i[NINE_POS];
      dir_d  = wdata_i[DIR_POS];
      inv_d  = wdata_i[INV_POS];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nine_q <= 1'b0;
      dir_q  <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      nine_q <= nine_d;
      dir_q  <= dir_d;
      inv_q  <= inv_d;
    end
  end

  assign nine_o = nine_q;
  assign dir_o  = dir_q;
  assign inv_o  = inv_q;
endmodule

// File: rtl/uart9_txbuf.sv
module uart9_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              nine_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W:0]   word_o,
  output logic              empty_flag_o
);
  logic            full_q, full_d;
  logic            flag_q, flag_d;
  logic [DATA_W:0] word_q, word_d;

  always_comb begin
    full_d = full_q;
    flag_d = flag_q;
    word_d = word_q;
    if (take_i) begin
      full_d = 1'b0;
      flag_d = 1'b1;
    end
    if (wr_i) begin
      full_d = 1'b1;
      flag_d = 1'b0;
      word_d = {nine_i, data_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      flag_q <= 1'b1;
      word_q <= '0;
    end else begin
      full_q <= full_d;
      flag_q <= flag_d;
      if (wr_i) word_q <= word_d;
    end
  end

  assign full_o       = full_q;
  assign word_o       = word_q;
  assign empty_flag_o = flag_q;
endmodule

// File: rtl/uart9_shifter.sv
module uart9_shifter
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            nine_mode_i,
  input  logic            brk_req_i,
  input  logic            buf_full_i,
  input  logic [DATA_W:0] buf_word_i,
  output logic            take_o,
  output logic            busy_o,
  output logic            line_o
);
  localparam int SH_W  = DATA_W + 3;
  localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BIT_W = $clog2(SH_W + 1);
  localparam logic [BIT_W-1:0] LAST_LONG  = BIT_W'(SH_W - 1);
  localparam logic [BIT_W-1:0] LAST_SHORT = BIT_W'(SH_W - 2);
  localparam logic [CNT_W-1:0] TICK_LAST  = CNT_W'(OVS - 1);

  sh_state_e        state_q, state_d;
  logic [SH_W-1:0]  shreg_q, shreg_d;
  logic [CNT_W-1:0] tick_q, tick_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [BIT_W-1:0] last_q, last_d;
  logic             take;
  logic             ninth_val;

  assign take      = (state_q == SH_IDLE) && !brk_req_i && buf_full_i;
  assign ninth_val = nine_mode_i ? buf_word_i[DATA_W] : 1'b1;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    tick_d  = tick_q;
    bit_d   = bit_q;
    last_d  = last_q;
    case (state_q)
      SH_IDLE: begin
        if (brk_req_i || buf_full_i) begin
          state_d = brk_req_i ? SH_BRK : SH_DATA;
          tick_d  = '0;
          bit_d   = '0;
          last_d  = nine_mode_i ? LAST_LONG : LAST_SHORT;
          if (!brk_req_i) begin
            shreg_d = {1'b1, ninth_val, buf_word_i[DATA_W-1:0], 1'b0};
          end
        end
      end
      default: begin
        if (tick_i) begin
          if (tick_q == TICK_LAST) begin
            tick_d  = '0;
            shreg_d = {1'b1, shreg_q[SH_W-1:1]};
            if (bit_q == last_q) begin
              if (state_q == SH_BRK && brk_req_i) begin
                bit_d  = '0;
                last_d = nine_mode_i ? LAST_LONG : LAST_SHORT;
              end else begin
                state_d = SH_IDLE;
              end
            end else begin
              bit_d = bit_q + BIT_W'(1);
            end
          end else begin
            tick_d = tick_q + CNT_W'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      shreg_q <= '1;
      tick_q  <= '0;
      bit_q   <= '0;
      last_q  <= LAST_SHORT;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      tick_q  <= tick_d;
      bit_q   <= bit_d;
      last_q  <= last_d;
    end
  end

  always_comb begin
    case (state_q)
      SH_DATA: line_o = shreg_q[0];
      SH_BRK:  line_o = 1'b0;
      default: line_o = 1'b1;
    endcase
  end

  assign take_o = take;
  assign busy_o = (state_q != SH_IDLE);
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              nine_bit_i,
  input  logic              sw_loop_i,
  input  logic              sw_src_i,
  input  logic              ctl_wr_i,
  input  logic [7:0]        ctl_i,
  input  logic              dat_wr_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              brk_req_i,
  output logic              tx_o,
  output logic              tx_oe_o,
  output logic              rx_loop_o,
  output logic              tde_o
);
  logic            nine_bit, dir_out, inv;
  logic            buf_full, take, busy, line;
  logic [DATA_W:0] buf_word;

  uart9_ctl #(.CTL_W(8)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctl_wr_i),
    .wdata_i (ctl_i),
    .nine_o  (nine_bit),
    .dir_o   (dir_out),
    .inv_o   (inv)
  );

  uart9_txbuf #(.DATA_W(DATA_W)) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (dat_wr_i),
    .data_i       (dat_i),
    .nine_i       (nine_bit),
    .take_i       (take),
    .full_o       (buf_full),
    .word_o       (buf_word),
    .empty_flag_o (tde_o)
  );

  uart9_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_sh (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (baud_tick_i),
    .nine_mode_i (nine_bit_i),
    .brk_req_i   (brk_req_i),
    .buf_full_i  (buf_full),
    .buf_word_i  (buf_word),
    .take_o      (take),
    .busy_o      (busy),
    .line_o      (line)
  );

  assign tx_o      = line ^ inv;
  assign rx_loop_o = line;
  assign tx_oe_o   = !(sw_loop_i && sw_src_i && !dir_out);
endmodule

// File: rtl/uart9_tx_chk.sv
module uart9_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic baud_tick_i,
  input logic sw_loop_i,
  input logic sw_src_i,
  input logic dat_wr_i,
  input logic brk_req_i,
  input logic tx_o,
  input logic tx_oe_o,
  input logic rx_loop_o,
  input logic tde_o,
  input logic take,
  input logic busy,
  input logic inv
);
  a_r10_loop_is_plain_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_loop_o == (tx_o ^ inv));

  a_r7_load_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !dat_wr_i) |=> tde_o);

  a_r7_write_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_wr_i |=> !tde_o);

  a_r2_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !baud_tick_i) |=> $stable(rx_loop_o));

  a_r6_break_goes_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && brk_req_i) |=> !rx_loop_o);

  a_r9_oe_only_in_single_wire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_oe_o |-> (sw_loop_i && sw_src_i));

  a_r8_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (tx_o == !inv));
endmodule

bind uart9_tx uart9_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .baud_tick_i (baud_tick_i),
  .sw_loop_i   (sw_loop_i),
  .sw_src_i    (sw_src_i),
  .dat_wr_i    (dat_wr_i),
  .brk_req_i   (brk_req_i),
  .tx_o        (tx_o),
  .tx_oe_o     (tx_oe_o),
  .rx_loop_o   (rx_loop_o),
  .tde_o       (tde_o),
  .take        (take),
  .busy        (busy),
  .inv         (inv)
);

// File: tb/sim_uart9_tx.sv
module sim_uart9_tx;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       nine_bit = 1'b0;
  logic       sw_loop = 1'b0;
  logic       sw_src = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl = 8'h00;
  logic       dat_wr = 1'b0;
  logic [7:0] dat = 8'h00;
  logic       brk_req = 1'b0;
  logic       tx, tx_oe, rx_loop, tde;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  uart9_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(baud_tick), .nine_bit_i(nine_bit),
    .sw_loop_i(sw_loop), .sw_src_i(sw_src), .ctl_wr_i(ctl_wr), .ctl_i(ctl),
    .dat_wr_i(dat_wr), .dat_i(dat), .brk_req_i(brk_req),
    .tx_o(tx), .tx_oe_o(tx_oe), .rx_loop_o(rx_loop), .tde_o(tde)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      baud_tick = ~baud_tick;
    end
  end

  // behavioural reference model
  int m_q[$];
  bit m_busy, m_brk, m_full, m_tde, m_t8, m_dir, m_inv;
  int m_buf, m_tick;

  task automatic fill_break();
    m_q.delete();
    repeat (nine_bit ? 11 : 10) m_q.push_back(0);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete();
      m_busy = 0; m_brk = 0; m_full = 0; m_tde = 1;
      m_t8 = 0; m_dir = 0; m_inv = 0; m_buf = 0; m_tick = 0;
    end else begin
      if (!m_busy) begin
        if (brk_req) begin
          fill_break();
          m_busy = 1; m_brk = 1; m_tick = 0;
        end else if (m_full) begin
          m_q.delete();
          m_q.push_back(0);
          for (int i = 0; i < 8; i++) m_q.push_back((m_buf >> i) & 1);
          if (nine_bit) m_q.push_back((m_buf >> 8) & 1);
          m_q.push_back(1);
          m_full = 0; m_tde = 1; m_busy = 1; m_brk = 0; m_tick = 0;
        end
      end else if (baud_tick) begin
        m_tick++;
        if (m_tick == 16) begin
          m_tick = 0;
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin
            if (m_brk && brk_req) fill_break();
            else m_busy = 0;
          end
        end
      end
      if (dat_wr) begin
        m_buf = int'(dat) | (int'(m_t8) << 8);
        m_full = 1; m_tde = 0;
      end
      if (ctl_wr) begin
        m_t8 = ctl[6]; m_dir = ctl[5]; m_inv = ctl[4];
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int line;
      line = m_busy ? m_q[0] : 1;
      check(tx == (line[0] ^ m_inv), "R2", "pin value", int'(tx), int'(line[0] ^ m_inv));
      check(rx_loop == line[0], "R10", "loop value", int'(rx_loop), line);
      check(tde == m_tde, "R7", "empty flag", int'(tde), int'(m_tde));
      check(tx_oe == !(sw_loop && sw_src && !m_dir), "R9", "output enable",
            int'(tx_oe), int'(!(sw_loop && sw_src && !m_dir)));
    end
  end

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl = v; ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat = v; dat_wr = 1'b1;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write a byte on an idle engine and sample the ninth bit in mid-bit
  task automatic send_check_ninth(input logic [7:0] v, input bit both, input logic [7:0] c,
                                  input bit exp, input string req);
    @(negedge clk); dat = v; dat_wr = 1'b1;
    if (both) begin ctl = c; ctl_wr = 1'b1; end
    @(negedge clk); dat_wr = 1'b0; ctl_wr = 1'b0;
    while (!tde) @(negedge clk);
    repeat (304) @(negedge clk);
    check(rx_loop == exp, req, "ninth bit", int'(rx_loop), int'(exp));
    idle_wait(200);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx == 1'b1, "R1", "idle pin", int'(tx), 1);
    check(tde == 1'b1, "R1", "empty flag", int'(tde), 1);
    check(tx_oe == 1'b1, "R1", "output enable", int'(tx_oe), 1);

    // R2 eight-bit frames
    wr_dat(8'hA5); idle_wait(400);
    wr_dat(8'h0F); idle_wait(400);

    // R3 nine-bit with ninth=1
    nine_bit = 1'b1;
    wr_ctl(8'h40);
    send_check_ninth(8'h3C, 1'b0, 8'h00, 1'b1, "R3");
    // R5 sticky ninth bit
    send_check_ninth(8'h00, 1'b0, 8'h00, 1'b1, "R5");
    // R4 same-cycle control write uses old value, next char uses new
    send_check_ninth(8'h11, 1'b1, 8'h00, 1'b1, "R4");
    send_check_ninth(8'hFF, 1'b0, 8'h00, 1'b0, "R4");

    // R7 write coinciding with load, then overwrite while full
    @(negedge clk); dat = 8'h55; dat_wr = 1'b1;
    @(negedge clk); dat = 8'hC3;
    @(negedge clk); dat_wr = 1'b0;
    check(tde == 1'b0, "R7", "flag after write at load", int'(tde), 0);
    idle_wait(50);
    wr_dat(8'h81);
    idle_wait(900);

    // R8 inversion at idle and in a frame
    wr_ctl(8'h10);
    @(negedge clk);
    check(tx == 1'b0, "R8", "inverted idle", int'(tx), 0);
    nine_bit = 1'b0;
    wr_dat(8'h6A); idle_wait(400);

    // R6 break, inverted, with a waiting byte
    @(negedge clk); brk_req = 1'b1; dat = 8'h99; dat_wr = 1'b1;
    @(negedge clk); dat_wr = 1'b0;
    idle_wait(20);
    check(tx == 1'b1, "R6", "inverted break pin", int'(tx), 1);
    check(rx_loop == 1'b0, "R6", "break line", int'(rx_loop), 0);
    idle_wait(500);
    brk_req = 1'b0;
    idle_wait(800);

    // R9 single-wire direction
    wr_ctl(8'h00);
    sw_loop = 1'b1; sw_src = 1'b1;
    @(negedge clk);
    check(tx_oe == 1'b0, "R9", "input direction", int'(tx_oe), 0);
    wr_ctl(8'h20);
    @(negedge clk);
    check(tx_oe == 1'b1, "R9", "output direction", int'(tx_oe), 1);
    wr_ctl(8'h00);
    sw_src = 1'b0;
    @(negedge clk);
    check(tx_oe == 1'b1, "R9", "not single-wire", int'(tx_oe), 1);
    wr_dat(8'h24); idle_wait(400);
    check(rx_loop == 1'b1, "R10", "loop idle after frame", int'(rx_loop), 1);

    finish_run();
  end
endmodule